// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches two independent ports that share one storage array and decides, on a single clock, which port may use a word when both point at it. Each port supplies an active-high enable, a write strobe, a semaphore-space select and a word address. When both enabled ports address the same array word, the port that was already there keeps the word and the other port is shown an active-low busy flag. If both arrive in the same clock, the left port is chosen.

The block also filters writes. A write strobe from a port that is busy is held back from the array and reported on a drop pulse, while a write from a free port is passed on a go pulse. A mode input selects master or slave behaviour. In master mode the block arbitrates and its busy outputs carry the decision. In slave mode, used when several instances are ganged for a wider word, its own arbitration is off. The busy inputs from the master are registered onto the busy outputs, and writes are held until that busy has been released and has settled for one cycle.

Top module: `dp_contend_arb`

## Requirements
- R1: While reset is held and just after it, both busy outputs are high and every go and drop output is low.
- R2: In master mode, a busy output goes low only when, on the previous clock, both ports were enabled, neither selected semaphore space, and their addresses were equal.
- R3: When one port has held an address for at least one clock and the other port then moves onto that address, only the newcomer sees busy.
- R4: Busy also fires when a port's enable rises while the two addresses already match, and it goes to the port whose enable rose last.
- R5: Busy is released one clock after the addresses differ or after either enable falls.
- R6: When both ports reach the same address in the same clock, the left port wins and only the right busy goes low. The two busy outputs are never low together in master mode.
- R7: An access with the semaphore select high never takes part in contention, even at an equal address.
- R8: A write (enable high, semaphore select low, write strobe high) from a port that loses contention gives a drop pulse and no go pulse, one clock later. A write from a port that is not busy gives a go pulse.
- R9: In slave mode, each busy output equals its busy input as sampled on the previous clock, and matching addresses raise no busy.
- R10: In slave mode, a write is dropped while the busy input is low and in the first clock after it is released, and it passes from the second clock on.
- R11: All outputs are registered and change one clock after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = follow busy inputs |
| l_ce | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write strobe |
| l_sem | input | 1 | Left port selects semaphore space |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write strobe |
| r_sem | input | 1 | Right port selects semaphore space |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | Busy from master toward left, used in slave mode |
| r_busy_in_n | input | 1 | Busy from master toward right, used in slave mode |
| l_busy_n | output | 1 | Busy toward left port, active low |
| r_busy_n | output | 1 | Busy toward right port, active low |
| l_wr_go | output | 1 | Left write passed to the array |
| r_wr_go | output | 1 | Right write passed to the array |
| l_wr_drop | output | 1 | Left write suppressed |
| r_wr_drop | output | 1 | Right write suppressed |

## Verification
Two things can happen in the same clock: the decision on who arrived first, and the write from the port that loses. The bench provokes both by moving both ports onto one address in the same clock with both strobes high. It then expects the right busy low, a go pulse on the left and a drop on the right. It also moves a writing port onto an address that is already held. There, the busy flag and the drop pulse must appear in the same clock, with no go pulse leaking through on the first clock of the collision.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
  localparam int unsigned PORTS = 2;
  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;
endpackage

// File: rtl/dpa_port_track.sv
// Remembers where a port was one clock ago so arrival order can be judged.
module dpa_port_track #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr;
    end
  end

  // present now and already at this same word on the previous clock
  assign settled = act & act_q & (addr_q == addr);
endmodule

// File: rtl/dpa_owner_fsm.sv
// Decides ownership of a contended word and registers the busy flags.
module dpa_owner_fsm
  import dpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic             match,
  input  logic [PORTS-1:0] settled,
  input  logic [PORTS-1:0] busy_in_n,
  output logic [PORTS-1:0] busy_n,
  output logic [PORTS-1:0] block
);
  own_e             own_q, own_d;
  logic [PORTS-1:0] busy_d;

  always_comb begin
    own_d = own_q;
    if (!master_mode || !match) begin
      own_d = OWN_NONE;
    end else if (own_q == OWN_NONE) begin
      if (settled[RIGHT] && !settled[LEFT]) own_d = OWN_RIGHT;
      else                                  own_d = OWN_LEFT;
    end
  end

  always_comb begin
    if (master_mode) begin
      busy_d[LEFT]  = (own_d != OWN_RIGHT);
      busy_d[RIGHT] = (own_d != OWN_LEFT);
      block         = ~busy_d;
    end else begin
      busy_d = busy_in_n;
      block  = ~busy_in_n | ~busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= OWN_NONE;
      busy_n <= '1;
    end else begin
      own_q  <= own_d;
      busy_n <= busy_d;
    end
  end
endmodule

// File: rtl/dpa_wr_gate.sv
// Passes or drops one port's array write.
module dpa_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic wr,
  input  logic block,
  output logic go,
  output logic drop
);
  logic want;
  logic go_d, drop_d;

  always_comb begin
    want   = act & wr;
    go_d   = want & ~block;
    drop_d = want &  block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go   <= 1'b0;
      drop <= 1'b0;
    end else begin
      go   <= go_d;
      drop <= drop_d;
    end
  end
endmodule

// File: rtl/dp_contend_arb.sv
module dp_contend_arb
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_wr,
  input  logic              l_sem,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic              r_wr,
  input  logic              r_sem,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_go,
  output logic              r_wr_go,
  output logic              l_wr_drop,
  output logic              r_wr_drop
);
  logic [PORTS-1:0]             act, wr, settled, block, go, drop, busy_n, busy_in_n;
  logic [PORTS-1:0][ADDR_W-1:0] addr;
  logic                         match;

  // array access only: semaphore-space accesses are excluded
  assign act       = {r_ce & ~r_sem, l_ce & ~l_sem};
  assign wr        = {r_wr, l_wr};
  assign addr      = {r_addr, l_addr};
  assign busy_in_n = {r_busy_in_n, l_busy_in_n};
  assign match     = act[LEFT] & act[RIGHT] & (addr[LEFT] == addr[RIGHT]);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) i_track (
      .clk(clk), .rst_n(rst_n), .act(act[p]), .addr(addr[p]), .settled(settled[p])
    );
    dpa_wr_gate i_gate (
      .clk(clk), .rst_n(rst_n), .act(act[p]), .wr(wr[p]), .block(block[p]),
      .go(go[p]), .drop(drop[p])
    );
  end

  dpa_owner_fsm i_owner (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .match(match),
    .settled(settled), .busy_in_n(busy_in_n), .busy_n(busy_n), .block(block)
  );

  assign l_busy_n  = busy_n[LEFT];
  assign r_busy_n  = busy_n[RIGHT];
  assign l_wr_go   = go[LEFT];
  assign r_wr_go   = go[RIGHT];
  assign l_wr_drop = drop[LEFT];
  assign r_wr_drop = drop[RIGHT];
endmodule

// File: rtl/dpa_arb_chk.sv
module dpa_arb_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_ce,
  input logic              l_sem,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_ce,
  input logic              r_sem,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_go,
  input logic              l_wr_drop,
  input logic              r_wr_go,
  input logic              r_wr_drop
);
  logic hit;
  assign hit = l_ce & ~l_sem & r_ce & ~r_sem & (l_addr == r_addr);

  // R2
  busy_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && !l_busy_n) |-> $past(hit));
  // R6
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_mode) |-> (l_busy_n || r_busy_n));
  // R5
  release_on_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_mode) && !$past(r_ce)) |-> l_busy_n);
  // R8
  go_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_wr_go && l_wr_drop) && !(r_wr_go && r_wr_drop));
  // R8
  drop_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_mode) && r_wr_drop) |-> !r_busy_n);
  // R9
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master_mode) |-> (l_busy_n == $past(l_busy_in_n)));
endmodule

bind dp_contend_arb dpa_arb_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .l_ce(l_ce), .l_sem(l_sem), .l_addr(l_addr),
  .r_ce(r_ce), .r_sem(r_sem), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_go(l_wr_go), .l_wr_drop(l_wr_drop), .r_wr_go(r_wr_go), .r_wr_drop(r_wr_drop)
);

// File: tb/test_dp_contend_arb.sv
module test_dp_contend_arb;
  localparam int unsigned AW = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic master_mode;
  logic l_ce, l_wr, l_sem, r_ce, r_wr, r_sem, l_busy_in_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_wr_drop, r_wr_drop;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dp_contend_arb #(.ADDR_W(AW)) i_dp_contend_arb (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_wr(l_wr), .l_sem(l_sem), .l_addr(l_addr),
    .r_ce(r_ce), .r_wr(r_wr), .r_sem(r_sem), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_go(l_wr_go), .r_wr_go(r_wr_go), .l_wr_drop(l_wr_drop), .r_wr_drop(r_wr_drop)
  );

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {lb,rb,lgo,rgo,ldrop,rdrop} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_wr_drop, r_wr_drop};
  endfunction

  // drive at negedge, step through one rising edge, sample 1 ns later
  task automatic step(input logic m, input logic lc, input logic lw, input logic ls,
                      input logic [AW-1:0] la, input logic rc, input logic rw,
                      input logic rs, input logic [AW-1:0] ra,
                      input logic lbi, input logic rbi);
    @(negedge clk);
    master_mode = m;
    l_ce = lc; l_wr = lw; l_sem = ls; l_addr = la;
    r_ce = rc; r_wr = rw; r_sem = rs; r_addr = ra;
    l_busy_in_n = lbi; r_busy_in_n = rbi;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    master_mode = 1'b1;
    l_ce = 0; l_wr = 0; l_sem = 0; l_addr = 0;
    r_ce = 0; r_wr = 0; r_sem = 0; r_addr = 0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", outs(), 6'b110000);
    @(negedge clk) rst_n = 1'b1;
    idle();
    chk("R1 after reset", outs(), 6'b110000);
  endtask

  task automatic t_left_first();
    step(1, 1, 0, 0, 5, 0, 0, 0, 0, 1, 1);
    chk("R2 lone port no busy", outs(), 6'b110000);
    step(1, 1, 0, 0, 5, 1, 0, 0, 4, 1, 1);
    chk("R2 different address", outs(), 6'b110000);
    step(1, 1, 0, 0, 5, 1, 1, 0, 5, 1, 1);
    chk("R3 R8 R11 right joins later", outs(), 6'b100001);
    step(1, 1, 0, 0, 5, 1, 1, 0, 6, 1, 1);
    chk("R5 release on mismatch", outs(), 6'b110100);
    idle();
  endtask

  task automatic t_right_first();
    step(1, 0, 0, 0, 3, 1, 0, 0, 3, 1, 1);
    step(1, 1, 1, 0, 3, 1, 0, 0, 3, 1, 1);
    chk("R3 R8 left joins later", outs(), 6'b010010);
    step(1, 1, 1, 0, 3, 1, 0, 0, 3, 1, 1);
    chk("R3 owner kept", outs(), 6'b010010);
    idle();
  endtask

  task automatic t_ce_trigger();
    step(1, 1, 0, 0, 9, 0, 0, 0, 9, 1, 1);
    step(1, 1, 0, 0, 9, 1, 0, 0, 9, 1, 1);
    chk("R4 right enable rises on match", outs(), 6'b100000);
    step(1, 0, 0, 0, 9, 1, 0, 0, 9, 1, 1);
    chk("R5 release on enable fall", outs(), 6'b110000);
    step(1, 1, 0, 0, 9, 1, 0, 0, 9, 1, 1);
    chk("R4 left enable rises last", outs(), 6'b010000);
    idle();
  endtask

  task automatic t_tie();
    step(1, 1, 1, 0, 7, 1, 1, 0, 7, 1, 1);
    chk("R6 R8 same clock tie left wins", outs(), 6'b101001);
    idle();
  endtask

  task automatic t_sem();
    step(1, 1, 0, 1, 2, 1, 0, 1, 2, 1, 1);
    step(1, 1, 0, 1, 2, 1, 0, 1, 2, 1, 1);
    chk("R7 both semaphore", outs(), 6'b110000);
    step(1, 1, 0, 0, 2, 1, 1, 1, 2, 1, 1);
    chk("R7 one semaphore", outs(), 6'b110000);
    idle();
  endtask

  task automatic t_slave();
    step(0, 1, 0, 0, 8, 1, 0, 0, 8, 1, 1);
    chk("R9 slave ignores own match", outs(), 6'b110000);
    step(0, 1, 1, 0, 8, 0, 0, 0, 0, 0, 1);
    chk("R9 R10 busy input low", outs(), 6'b010010);
    step(0, 1, 1, 0, 8, 0, 0, 0, 0, 1, 1);
    chk("R10 first clock after release", outs(), 6'b110010);
    step(0, 1, 1, 0, 8, 0, 0, 0, 0, 1, 0);
    chk("R9 R10 settled release passes", outs(), 6'b101000);
    idle();
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_left_first();
        t_right_first();
        t_ce_trigger();
        t_tie();
        t_sem();
        t_slave();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: actual=hung expected=finished");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule